// File: doc/BRIEF.md
# DRAM Strobe Sequencer with CAS-before-RAS Refresh

The block lets a processor core reach an external DRAM that has an 8-bit data bus and an 11-bit address bus. The row and column share that bus. Each core request carries a 22-bit address, with the row in the upper 11 bits and the column in the lower 11 bits, plus a write flag and write data. The block turns each request into row and column strobe sequences. Every width and gap in those sequences is a whole number of clock cycles. A timing select input picks one of two cycle sets, slow or fast, and the block latches that choice when it leaves idle.

While the row strobe stays low, the block serves consecutive requests to the same row as extra column pulses. A request to another row closes the page, waits out the precharge and opens the new row. A refresh timer asks for a CAS-before-RAS refresh every `cfg_ref_period + 1` cycles. A pending refresh ends any open page at the next access boundary. It also wins over a waiting request when the sequencer is idle. So, with refresh on, the strobes keep cycling through refreshes even when the core is quiet.

The request side is a valid/ready channel. The core raises `req_valid` and holds the address, write flag and write data stable until it sees `req_ready`. `req_ready` is high for exactly one cycle: the last cycle of the column pulse for that request. The transfer completes at the end of that cycle. The core may present the next request in the following cycle to stay in page mode. The response channel has no back-pressure: read data comes back with a one-cycle `rsp_valid` pulse, and the core must take it.

Top module: `dram_ctrl`

## Requirements
- R1: During and directly after reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe`, `req_ready` and `rsp_valid` are low.
- R2: In a single access the row strobe is low for 7 cycles in slow mode (`cfg_fast`=0) and 5 cycles in fast mode (`cfg_fast`=1). After any row strobe deassertion it stays high for at least 5 (slow) or 3 (fast) cycles.
- R3: Each column pulse in an access is low for 3 cycles (slow) or 2 cycles (fast). The row address is on `dram_addr` from one cycle before the row strobe falls until the column pulse. The column address is on the bus during the column pulse.
- R4: In a write, `dram_we_n` falls 4 cycles (slow) or 3 cycles (fast) before the column strobe falls, and stays low through the column pulse. `dram_dq_oe` is high, with the write data on `dram_dq_out`, only during the column pulse. In a read, `dram_oe_n` is low exactly during the column pulse.
- R5: `req_ready` is high only in the last cycle of a request's column pulse. For a read, `rsp_valid` pulses in the next cycle, with `rsp_data` equal to `dram_dq_in` as sampled in that last cycle.
- R6: After a column pulse, the row strobe stays low for one decision cycle. If a request to the same row is valid then, a new column pulse for it starts after a further 4 (slow) or 3 (fast) cycles, and the row strobe does not rise in between.
- R7: If no request is valid in the decision cycle, or the valid request has a different row, the row strobe rises. The block then precharges and opens the requested row through a full access sequence.
- R8: A refresh holds the column strobe low for one cycle with the row strobe high. Both strobes are then low for 7 (slow) or 5 (fast) cycles, and both return high together, followed by precharge.
- R9: With `cfg_ref_en`=1, a refresh becomes pending every `cfg_ref_period + 1` cycles. With `cfg_ref_en`=0, no refresh is pending and no refresh cycles occur.
- R10: A pending refresh is served before a waiting request when idle. In the decision cycle it closes an open page, even if a same-row request is valid.
- R11: The timing mode of a sequence is fixed when the sequence leaves idle. Changing `cfg_fast` in mid-sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fast | input | 1 | 1 selects the fast cycle set, 0 the slow one |
| cfg_ref_en | input | 1 | Enables periodic refresh |
| cfg_ref_period | input | 16 | Refresh interval minus one, in cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (last column cycle) |
| req_addr | input | 22 | Row in bits 21:11, column in bits 10:0 |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
Two things can fall in the same cycle: a refresh request and the page-mode decision for a same-row request that the core has already presented. The bench provokes this by running long same-row bursts while the refresh interval is short, so the timer keeps firing in the middle of bursts. The same setup makes pending refreshes collide with requests that wait at idle. A behavioural model in the bench predicts every pin on every cycle, with its own refresh countdown. It expects the page to close, a refresh to run, and the waiting request to resume as a fresh row access. Any cycle where the pins differ from that prediction is reported against the requirement of the phase in progress.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ROW,
    ST_CAS,
    ST_WIN,
    ST_PGAP,
    ST_PRE,
    ST_RFC,
    ST_RFR
  } seq_state_t;

  typedef struct packed {
    logic [3:0] cas;
    logic [3:0] wlead;
    logic [3:0] pre;
    logic [3:0] ras;
  } dram_timing_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [REF_W-1:0] period,
  input  logic             start,
  output logic             pend
);
  logic [REF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (!en) begin
      cnt  <= period;
      pend <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= period;
      pend <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (start) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 4,
  parameter int SLOW_CAS   = 3,
  parameter int SLOW_WLEAD = 4,
  parameter int SLOW_PRE   = 5,
  parameter int FAST_CAS   = 2,
  parameter int FAST_WLEAD = 3,
  parameter int FAST_PRE   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_fast,
  input  logic                   req_valid,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   ref_pend,
  output logic                   ref_start,
  output logic                   acc_ready,
  output seq_state_t             st,
  output logic [ROW_W-1:0]       row_q,
  output logic [COL_W-1:0]       col_q,
  output logic                   we_q,
  output logic [DATA_W-1:0]      wd_q
);
  localparam int ADDR_W = ROW_W + COL_W;

  dram_timing_t slow_t, fast_t, tim;
  logic [CNT_W-1:0] cnt;
  logic             fast_q;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             same_row;

  assign slow_t = '{cas: 4'(SLOW_CAS), wlead: 4'(SLOW_WLEAD), pre: 4'(SLOW_PRE),
                    ras: 4'(SLOW_WLEAD + SLOW_CAS)};
  assign fast_t = '{cas: 4'(FAST_CAS), wlead: 4'(FAST_WLEAD), pre: 4'(FAST_PRE),
                    ras: 4'(FAST_WLEAD + FAST_CAS)};
  assign tim    = fast_q ? fast_t : slow_t;

  assign req_row   = req_addr[ADDR_W-1:COL_W];
  assign req_col   = req_addr[COL_W-1:0];
  assign same_row  = (req_row == row_q);
  assign ref_start = (st == ST_IDLE) && ref_pend;
  assign acc_ready = (st == ST_CAS) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      fast_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (ref_pend) begin
            st     <= ST_RFC;
            fast_q <= cfg_fast;
          end else if (req_valid) begin
            st     <= ST_SETUP;
            fast_q <= cfg_fast;
            row_q  <= req_row;
            col_q  <= req_col;
            we_q   <= req_we;
            wd_q   <= req_wdata;
          end
        end
        ST_SETUP: begin
          st  <= ST_ROW;
          cnt <= CNT_W'(tim.wlead - 4'd2);
        end
        ST_ROW: begin
          if (cnt == '0) begin
            st  <= ST_CAS;
            cnt <= CNT_W'(tim.cas - 4'd1);
          end else cnt <= cnt - 1'b1;
        end
        ST_CAS: begin
          if (cnt == '0) st <= ST_WIN;
          else cnt <= cnt - 1'b1;
        end
        ST_WIN: begin
          if (req_valid && same_row && !ref_pend) begin
            st    <= ST_PGAP;
            cnt   <= CNT_W'(tim.wlead - 4'd1);
            col_q <= req_col;
            we_q  <= req_we;
            wd_q  <= req_wdata;
          end else begin
            st  <= ST_PRE;
            cnt <= CNT_W'(tim.pre - 4'd1);
          end
        end
        ST_PGAP: begin
          if (cnt == '0) begin
            st  <= ST_CAS;
            cnt <= CNT_W'(tim.cas - 4'd1);
          end else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_RFC: begin
          st  <= ST_RFR;
          cnt <= CNT_W'(tim.ras - 4'd1);
        end
        ST_RFR: begin
          if (cnt == '0) begin
            st  <= ST_PRE;
            cnt <= CNT_W'(tim.pre - 4'd1);
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_pins.sv
module dram_pins
  import dram_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seq_state_t           st,
  input  logic [ROW_W-1:0]     row_q,
  input  logic [COL_W-1:0]     col_q,
  input  logic                 we_q,
  input  logic [DATA_W-1:0]    wd_q,
  input  logic                 acc_ready,
  input  logic [DATA_W-1:0]    dq_in,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic                 oe_n,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data
);
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic row_phase, col_phase, ras_low, cas_low, we_win;

  assign row_phase = (st == ST_SETUP) || (st == ST_ROW);
  assign col_phase = (st == ST_CAS) || (st == ST_WIN) || (st == ST_PGAP);
  assign ras_low   = (st == ST_ROW) || (st == ST_CAS) || (st == ST_WIN) ||
                     (st == ST_PGAP) || (st == ST_RFR);
  assign cas_low   = (st == ST_CAS) || (st == ST_RFC) || (st == ST_RFR);
  assign we_win    = (st == ST_SETUP) || (st == ST_ROW) || (st == ST_CAS) ||
                     (st == ST_PGAP);

  always_comb begin
    addr = '0;
    if (row_phase)      addr = MUX_W'(row_q);
    else if (col_phase) addr = MUX_W'(col_q);
  end

  assign ras_n  = !ras_low;
  assign cas_n  = !cas_low;
  assign we_n   = !(we_q && we_win);
  assign oe_n   = !(!we_q && (st == ST_CAS));
  assign dq_oe  = we_q && (st == ST_CAS);
  assign dq_out = dq_oe ? wd_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_ready && !we_q;
      if (acc_ready && !we_q) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 11,
  parameter int DATA_W     = 8,
  parameter int REF_W      = 16,
  parameter int CNT_W      = 4,
  parameter int SLOW_CAS   = 3,
  parameter int SLOW_WLEAD = 4,
  parameter int SLOW_PRE   = 5,
  parameter int FAST_CAS   = 2,
  parameter int FAST_WLEAD = 3,
  parameter int FAST_PRE   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_fast,
  input  logic                   cfg_ref_en,
  input  logic [REF_W-1:0]       cfg_ref_period,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  seq_state_t        st;
  logic              ref_pend, ref_start, acc_ready, we_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wd_q;

  dram_refresh_timer #(.REF_W(REF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(cfg_ref_en), .period(cfg_ref_period),
    .start(ref_start), .pend(ref_pend)
  );

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .SLOW_CAS(SLOW_CAS), .SLOW_WLEAD(SLOW_WLEAD), .SLOW_PRE(SLOW_PRE),
    .FAST_CAS(FAST_CAS), .FAST_WLEAD(FAST_WLEAD), .FAST_PRE(FAST_PRE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .req_valid(req_valid),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .ref_pend(ref_pend), .ref_start(ref_start), .acc_ready(acc_ready),
    .st(st), .row_q(row_q), .col_q(col_q), .we_q(we_q), .wd_q(wd_q)
  );

  dram_pins #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st), .row_q(row_q), .col_q(col_q),
    .we_q(we_q), .wd_q(wd_q), .acc_ready(acc_ready), .dq_in(dram_dq_in),
    .addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_out(dram_dq_out),
    .dq_oe(dram_dq_oe), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign req_ready = acc_ready;
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic req_ready,
  input logic req_we,
  input logic rsp_valid
);
  logic [3:0] hi_cnt;
  logic [3:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 4'hF;
      lo_cnt <= 4'h0;
    end else begin
      if (ras_n) hi_cnt <= (hi_cnt == 4'hF) ? hi_cnt : hi_cnt + 4'd1;
      else       hi_cnt <= 4'h0;
      if (!cas_n) lo_cnt <= (lo_cnt == 4'hF) ? lo_cnt : lo_cnt + 4'd1;
      else        lo_cnt <= 4'h0;
    end
  end

  p_precharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 4'd3));

  p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (lo_cnt == 4'd2 || lo_cnt == 4'd3 || lo_cnt == 4'd6 || lo_cnt == 4'd8));

  p_we_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> (!$past(we_n, 1) && !$past(we_n, 2) && !$past(we_n, 3)));

  p_dq_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cas_n && !we_n && !ras_n));

  p_ready_in_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cas_n && !ras_n));

  p_rsp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_ready && !req_we));

  p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |=> (!cas_n && !ras_n));
endmodule

bind dram_ctrl dram_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .req_ready(req_ready),
  .req_we(req_we), .rsp_valid(rsp_valid)
);

// File: tb/tb_dram_ctrl.sv
`timescale 1ns/1ps
module tb_dram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fast = 1'b0, cfg_ref_en = 1'b0;
  logic [15:0] cfg_ref_period = 16'd40;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  dram_dq_out, dram_dq_in;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0, model_on = 0;

  always #2.5 clk = ~clk;

  dram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .cfg_ref_en(cfg_ref_en),
    .cfg_ref_period(cfg_ref_period), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  function automatic logic [7:0] pat(input logic [10:0] a);
    return a[7:0] ^ 8'h3C ^ {a[10:8], 5'b0};
  endfunction

  assign dram_dq_in = !dram_oe_n ? pat(dram_addr) : 8'h00;

  // ---------------- reference model ----------------
  logic [6:0]  e_ctl;   // {ras_n, cas_n, we_n, oe_n, dq_oe, ready, rsp_valid}
  logic [10:0] e_addr;
  logic [7:0]  e_dq, e_rd;
  string       e_tag = "R1";
  int          m_cnt = 0;
  bit          m_pend = 0, m_prev = 0, m_set = 0;

  task automatic emit(input logic [6:0] ctl, input logic [10:0] a,
                      input logic [7:0] dq, input logic [7:0] rd, input string tag);
    e_ctl = ctl; e_addr = a; e_dq = dq; e_rd = rd; e_tag = tag;
    @(posedge clk);
    m_prev = m_pend;
    m_set  = 0;
    if (!cfg_ref_en) begin
      m_cnt = int'(cfg_ref_period); m_pend = 0;
    end else if (m_cnt == 0) begin
      m_cnt = int'(cfg_ref_period); m_pend = 1; m_set = 1;
    end else m_cnt = m_cnt - 1;
  endtask

  initial begin : model
    bit fast, w, go_page;
    logic [10:0] row, col;
    logic [7:0]  d;
    int nc, nw, np, nr;
    @(posedge rst_n);
    model_on = 1;
    forever begin
      emit(7'b1111000, 11'd0, 8'd0, 8'd0, "R10");
      fast = cfg_fast;
      nc = fast ? 2 : 3; nw = fast ? 3 : 4; np = fast ? 3 : 5; nr = nc + nw;
      if (m_prev) begin
        if (!m_set) m_pend = 0;
        emit(7'b1011000, 11'd0, 8'd0, 8'd0, "R9");
        for (int i = 0; i < nr; i++) emit(7'b0011000, 11'd0, 8'd0, 8'd0, "R8");
        for (int i = 0; i < np; i++) emit(7'b1111000, 11'd0, 8'd0, 8'd0, "R8");
      end else if (req_valid) begin
        row = req_addr[21:11]; col = req_addr[10:0]; w = req_we; d = req_wdata;
        emit({3'b11, ~w, 4'b1000}, row, 8'd0, 8'd0, "R3");
        for (int i = 0; i < nw - 1; i++) emit({2'b01, ~w, 4'b1000}, row, 8'd0, 8'd0, "R2");
        go_page = 1;
        while (go_page) begin
          for (int i = 0; i < nc; i++)
            emit({2'b00, ~w, ~(~w), w, (i == nc - 1), 1'b0}, col, w ? d : 8'd0, 8'd0,
                 w ? "R4" : "R5");
          emit({6'b011100, ~w}, col, 8'd0, w ? 8'd0 : pat(col), "R5");
          if (req_valid && req_addr[21:11] == row && !m_prev) begin
            col = req_addr[10:0]; w = req_we; d = req_wdata;
            for (int i = 0; i < nw; i++) emit({2'b01, ~w, 4'b1000}, col, 8'd0, 8'd0, "R6");
          end else begin
            go_page = 0;
            for (int i = 0; i < np; i++) emit(7'b1111000, 11'd0, 8'd0, 8'd0, "R7");
          end
        end
      end
    end
  end

  // ---------------- comparison and monitors ----------------
  int ras_run = 0, last_ras_run = 0, cas_falls = 0;
  logic prev_cas = 1'b1;

  always @(negedge clk) begin
    logic [33:0] act, exp;
    if (rst_n) begin
      if (!dram_ras_n) ras_run++;
      else if (ras_run > 0) begin last_ras_run = ras_run; ras_run = 0; end
      if (prev_cas && !dram_cas_n) cas_falls++;
      prev_cas = dram_cas_n;
    end
    if (model_on && !done) begin
      act = {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, req_ready, rsp_valid,
             dram_addr, dram_dq_oe ? dram_dq_out : 8'd0, rsp_valid ? rsp_data : 8'd0};
      exp = {e_ctl, e_addr, e_dq, e_rd};
      checks++;
      if (act !== exp) begin
        failures++;
        $display("FAIL %s cycle %0d actual=%h expected=%h", e_tag, cycles, act, exp);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int a, input int e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic send(input logic [10:0] row, input logic [10:0] col,
                      input bit w, input logic [7:0] d);
    req_valid = 1; req_addr = {row, col}; req_we = w; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF && !dram_dq_oe &&
          !req_ready && !rsp_valid, "R1",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    rst_n = 1;
    idle(4);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF && !req_ready, "R1",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);

    // single accesses, slow then fast
    send(11'd5, 11'd3, 1, 8'h9A); idle(12);
    check(last_ras_run == 7, "R2", last_ras_run, 7);
    send(11'd5, 11'd3, 0, 8'h00); idle(12);
    cfg_fast = 1; idle(2);
    send(11'd6, 11'd77, 0, 8'h00); idle(12);
    check(last_ras_run == 5, "R2", last_ras_run, 5);
    send(11'd6, 11'd78, 1, 8'h44); idle(12);

    // page bursts with row changes, both modes
    for (int m = 0; m < 2; m++) begin
      cfg_fast = m[0]; idle(2);
      for (int i = 0; i < 4; i++) send(11'd9, 11'(i + 16), 1, 8'(i * 17 + 3));
      for (int i = 0; i < 4; i++) send(11'd9, 11'(i + 16), 0, 8'h00);
      send(11'd10, 11'd1, 0, 8'h00);
      send(11'd10, 11'd2, 1, 8'h5E);
      send(11'd1023, 11'd2047, 0, 8'h00);
      idle(15);
    end

    // mode change in mid-sequence
    cfg_fast = 0; idle(2);
    fork
      send(11'd3, 11'd4, 0, 8'h00);
      begin idle(3); cfg_fast = 1; end
    join
    idle(12);
    check(last_ras_run == 7, "R11", last_ras_run, 7);

    // refresh while idle, then refresh colliding with bursts
    cfg_ref_en = 1; cfg_ref_period = 16'd40;
    idle(200);
    cfg_ref_period = 16'd23;
    for (int k = 0; k < 12; k++) begin
      cfg_fast = k[0];
      for (int i = 0; i < 6; i++) send(11'(k + 2), 11'(i * 3), i[0], 8'(k * 13 + i));
      send(11'(k + 40), 11'd7, 0, 8'h00);
      idle(k % 5);
    end
    idle(40);

    // refresh disabled: no activity
    cfg_ref_en = 0; idle(10);
    cas_falls = 0;
    idle(300);
    check(cas_falls == 0, "R9", cas_falls, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule